// File: doc/BRIEF.md
# Interpolation Mode and Line Latency Controller

This block sits in the control section of a vertical reconstruction pipeline for widescreen letterbox video. It takes two system control bits, one for interpolation and one for film, and turns them into one of four operating modes: standard-signal bypass, camera-mode interpolation, multi-picture bypass, or film-mode interpolation. From that mode it drives the select signals that the luma and chroma filter paths use. Multi-picture bypass sits in the code where film is set and interpolation is clear, so the two bits cannot be read on their own.

The block also keeps a pixel counter that restarts on the horizontal reference and a line counter that restarts on the vertical reference. Mode and field parity are captured only when the vertical reference is seen, so a mode change never takes effect in the middle of a field. The line latency depends on mode and parity. The block subtracts it from the line counter to produce the number of the output line, and it flags as blank every line that falls before that latency. The filter coefficient phase, which steps through a cycle of four lines, is taken from the output line number.

Top module: `vrc_ctrl`

## Requirements
- R1: On a clock edge where `vref_i` is high, `mode_o` takes `{film_i, intpol_i}` and `even_o` takes `even_i`. The mode codes are 2'b00 standard bypass, 2'b01 camera interpolation, 2'b10 multi-picture bypass and 2'b11 film interpolation.
- R2: On edges where `vref_i` is low, `mode_o` and `even_o` hold their values whatever the control inputs do.
- R3: `pix_o` becomes 0 on the edge after `href_i` is sampled high. Otherwise it counts up by one per clock and wraps from PIX_PER_LINE-1 to 0.
- R4: `line_o` becomes 0 on an edge where `vref_i` is high. If `vref_i` is low and `href_i` is high, it counts up by one per edge and holds once it reaches LINE_MAX. If neither is high, it holds.
- R5: `delay_o` is 0 lines in standard bypass and 1 line in multi-picture bypass. With `even_o`=0 (first, odd field) it is 3 lines for camera mode and 2 lines for film mode. With `even_o`=1 (second, even field) it is 4 lines for camera mode and 3 lines for film mode.
- R6: `out_valid_o` is 1 when `line_o` >= `delay_o`. In that case `out_line_o` = `line_o` - `delay_o`; otherwise `out_line_o` is 0.
- R7: `interp_o` is 1 only in camera and film modes, `film_coef_o` only in film mode, and `pip_o` only in multi-picture mode. `chroma_taps_o` is 3 in camera mode, 4 in film mode and 0 in both bypass modes.
- R8: `coef_phase_o` equals the two low bits of `out_line_o` when `interp_o` and `out_valid_o` are both 1, and is 0 otherwise.
- R9: Reset puts the block in standard bypass with the odd field and both counters at 0. This gives `out_valid_o`=1 and `out_line_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Control clock (the slower pixel clock) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| href_i | input | 1 | Horizontal reference pulse, one per line |
| vref_i | input | 1 | Vertical reference pulse, one per field |
| intpol_i | input | 1 | Interpolation request bit |
| film_i | input | 1 | Film / multi-picture bit |
| even_i | input | 1 | Field parity: 1 even, 0 odd |
| mode_o | output | 2 | Captured operating mode code |
| even_o | output | 1 | Captured field parity |
| interp_o | output | 1 | Vertical interpolation enabled |
| film_coef_o | output | 1 | Film coefficient set selected |
| pip_o | output | 1 | Multi-picture bypass active |
| chroma_taps_o | output | 3 | Chroma filter line taps |
| delay_o | output | DLY_W | Line latency in lines |
| pix_o | output | PIX_W | Pixel counter |
| line_o | output | LINE_W | Input line counter |
| out_line_o | output | LINE_W | Output line number after latency |
| out_valid_o | output | 1 | Output line is past the latency (not blank) |
| coef_phase_o | output | 2 | Coefficient phase within four lines |

## Verification
The bench builds the block with PIX_PER_LINE=16 and LINE_MAX=15. With these values a line lasts sixteen clocks, so the pixel wrap comes up many times per field. A field of twenty lines drives the line counter into saturation, where the tag saturates along with it. The short lines also let a run cover every mode and parity pairing many times, including the blank lines at the start of each field. Random control bits that change on every cycle show that mode capture takes place only at the vertical reference.

// File: rtl/vrc_pkg.sv
package vrc_pkg;

    typedef enum logic [1:0] {
        MODE_STD  = 2'b00,
        MODE_CAM  = 2'b01,
        MODE_PIP  = 2'b10,
        MODE_FILM = 2'b11
    } vrc_mode_e;

    typedef struct packed {
        vrc_mode_e mode;
        logic      even;
    } vrc_ctl_s;

    localparam int unsigned TAPS_W = 3;

endpackage

// File: rtl/vrc_counter.sv
module vrc_counter #(
    parameter int unsigned W    = 10,
    parameter int unsigned MAX  = 1023,
    parameter bit          WRAP = 1'b1
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);

    localparam logic [W-1:0] LIMIT = W'(MAX);

    logic [W-1:0] cnt_d, cnt_q;
    logic [W-1:0] at_limit_d;

    generate
        if (WRAP) begin : g_wrap
            assign at_limit_d = '0;
        end else begin : g_sat
            assign at_limit_d = LIMIT;
        end
    endgenerate

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (inc_i) begin
            if (cnt_q == LIMIT) begin
                cnt_d = at_limit_d;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/vrc_mode_dec.sv
module vrc_mode_dec
    import vrc_pkg::*;
#(
    parameter int unsigned DLY_W         = 3,
    parameter int unsigned DLY_STD       = 0,
    parameter int unsigned DLY_PIP       = 1,
    parameter int unsigned DLY_CAM_ODD   = 3,
    parameter int unsigned DLY_CAM_EVEN  = 4,
    parameter int unsigned DLY_FILM_ODD  = 2,
    parameter int unsigned DLY_FILM_EVEN = 3
) (
    input  vrc_mode_e         mode_i,
    input  logic              even_i,
    output logic [DLY_W-1:0]  delay_o,
    output logic              interp_o,
    output logic              film_coef_o,
    output logic              pip_o,
    output logic [TAPS_W-1:0] taps_o
);

    always_comb begin
        delay_o     = DLY_W'(DLY_STD);
        interp_o    = 1'b0;
        film_coef_o = 1'b0;
        pip_o       = 1'b0;
        taps_o      = '0;
        unique case (mode_i)
            MODE_STD: begin
                delay_o = DLY_W'(DLY_STD);
            end
            MODE_PIP: begin
                delay_o = DLY_W'(DLY_PIP);
                pip_o   = 1'b1;
            end
            MODE_CAM: begin
                delay_o  = even_i ? DLY_W'(DLY_CAM_EVEN) : DLY_W'(DLY_CAM_ODD);
                interp_o = 1'b1;
                taps_o   = TAPS_W'(3);
            end
            MODE_FILM: begin
                delay_o     = even_i ? DLY_W'(DLY_FILM_EVEN) : DLY_W'(DLY_FILM_ODD);
                interp_o    = 1'b1;
                film_coef_o = 1'b1;
                taps_o      = TAPS_W'(4);
            end
            default: begin
                delay_o = DLY_W'(DLY_STD);
            end
        endcase
    end

endmodule

// File: rtl/vrc_ctrl.sv
module vrc_ctrl
    import vrc_pkg::*;
#(
    parameter int unsigned PIX_PER_LINE = 1024,
    parameter int unsigned LINE_MAX     = 1023,
    parameter int unsigned DLY_W        = 3,
    localparam int unsigned PIX_W       = $clog2(PIX_PER_LINE),
    localparam int unsigned LINE_W      = $clog2(LINE_MAX + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              href_i,
    input  logic              vref_i,
    input  logic              intpol_i,
    input  logic              film_i,
    input  logic              even_i,
    output logic [1:0]        mode_o,
    output logic              even_o,
    output logic              interp_o,
    output logic              film_coef_o,
    output logic              pip_o,
    output logic [2:0]        chroma_taps_o,
    output logic [DLY_W-1:0]  delay_o,
    output logic [PIX_W-1:0]  pix_o,
    output logic [LINE_W-1:0] line_o,
    output logic [LINE_W-1:0] out_line_o,
    output logic              out_valid_o,
    output logic [1:0]        coef_phase_o
);

    vrc_ctl_s ctl_d, ctl_q;

    // Mode and parity register: loaded only at the vertical reference.
    always_comb begin
        ctl_d = ctl_q;
        if (vref_i) begin
            ctl_d.mode = vrc_mode_e'({film_i, intpol_i});
            ctl_d.even = even_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctl_q <= '{mode: MODE_STD, even: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    vrc_counter #(
        .W    (PIX_W),
        .MAX  (PIX_PER_LINE - 1),
        .WRAP (1'b1)
    ) u_pix_cnt (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (href_i),
        .inc_i  (1'b1),
        .cnt_o  (pix_o)
    );

    vrc_counter #(
        .W    (LINE_W),
        .MAX  (LINE_MAX),
        .WRAP (1'b0)
    ) u_line_cnt (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (vref_i),
        .inc_i  (href_i),
        .cnt_o  (line_o)
    );

    logic [DLY_W-1:0]  dly_w;
    logic [TAPS_W-1:0] taps_w;

    vrc_mode_dec #(
        .DLY_W (DLY_W)
    ) u_dec (
        .mode_i      (ctl_q.mode),
        .even_i      (ctl_q.even),
        .delay_o     (dly_w),
        .interp_o    (interp_o),
        .film_coef_o (film_coef_o),
        .pip_o       (pip_o),
        .taps_o      (taps_w)
    );

    // Output line tag: input line minus the mode latency, blank before it.
    logic [LINE_W-1:0] dly_ext;
    logic              tag_ok;

    always_comb begin
        dly_ext    = LINE_W'(dly_w);
        tag_ok     = (line_o >= dly_ext);
        out_line_o = tag_ok ? (line_o - dly_ext) : '0;
        coef_phase_o = (tag_ok && interp_o) ? out_line_o[1:0] : 2'b00;
    end

    assign mode_o        = ctl_q.mode;
    assign even_o        = ctl_q.even;
    assign delay_o       = dly_w;
    assign chroma_taps_o = taps_w;
    assign out_valid_o   = tag_ok;

endmodule

// File: rtl/vrc_ctrl_chk.sv
module vrc_ctrl_chk #(
    parameter int unsigned PIX_W    = 10,
    parameter int unsigned LINE_W   = 10,
    parameter int unsigned DLY_W    = 3,
    parameter int unsigned PIX_MAX  = 1023,
    parameter int unsigned LINE_MAX = 1023
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              href_i,
    input logic              vref_i,
    input logic              intpol_i,
    input logic              film_i,
    input logic              even_i,
    input logic [1:0]        mode_o,
    input logic              even_o,
    input logic              interp_o,
    input logic              pip_o,
    input logic [2:0]        chroma_taps_o,
    input logic [DLY_W-1:0]  delay_o,
    input logic [PIX_W-1:0]  pix_o,
    input logic [LINE_W-1:0] line_o,
    input logic [LINE_W-1:0] out_line_o,
    input logic              out_valid_o
);

    AST_MODE_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vref_i |=> (mode_o == $past({film_i, intpol_i})) && (even_o == $past(even_i))); // R1

    AST_MODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !vref_i |=> $stable(mode_o) && $stable(even_o)); // R2

    AST_PIX_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        href_i |=> (pix_o == '0)); // R3

    AST_PIX_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!href_i && pix_o != PIX_W'(PIX_MAX)) |=> (pix_o == $past(pix_o) + 1'b1)); // R3

    AST_LINE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vref_i |=> (line_o == '0)); // R4

    AST_LINE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (href_i && !vref_i && line_o != LINE_W'(LINE_MAX)) |=> (line_o == $past(line_o) + 1'b1)); // R4

    AST_PIP_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pip_o |-> (delay_o == DLY_W'(1))); // R5

    AST_TAG_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (href_i && !vref_i && out_valid_o && line_o != LINE_W'(LINE_MAX))
            |=> out_valid_o && (out_line_o == $past(out_line_o) + 1'b1)); // R6

    AST_SEL_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(interp_o && pip_o)); // R7

    AST_TAPS_INTERP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        interp_o |-> (chroma_taps_o == 3'd3 || chroma_taps_o == 3'd4)); // R7

endmodule

bind vrc_ctrl vrc_ctrl_chk #(
    .PIX_W    (PIX_W),
    .LINE_W   (LINE_W),
    .DLY_W    (DLY_W),
    .PIX_MAX  (PIX_PER_LINE - 1),
    .LINE_MAX (LINE_MAX)
) u_vrc_ctrl_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .href_i        (href_i),
    .vref_i        (vref_i),
    .intpol_i      (intpol_i),
    .film_i        (film_i),
    .even_i        (even_i),
    .mode_o        (mode_o),
    .even_o        (even_o),
    .interp_o      (interp_o),
    .pip_o         (pip_o),
    .chroma_taps_o (chroma_taps_o),
    .delay_o       (delay_o),
    .pix_o         (pix_o),
    .line_o        (line_o),
    .out_line_o    (out_line_o),
    .out_valid_o   (out_valid_o)
);

// File: tb/vrc_ctrl_bench.sv
module vrc_ctrl_bench;

    localparam int PPL   = 16;
    localparam int LMAX  = 15;
    localparam int DW    = 3;
    localparam int PW    = $clog2(PPL);
    localparam int LW    = $clog2(LMAX + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic href = 1'b0, vref = 1'b0, intpol = 1'b0, film = 1'b0, even = 1'b0;

    logic [1:0]    mode_o;
    logic          even_o, interp_o, film_coef_o, pip_o, out_valid_o;
    logic [2:0]    taps_o;
    logic [DW-1:0] delay_o;
    logic [PW-1:0] pix_o;
    logic [LW-1:0] line_o, out_line_o;
    logic [1:0]    phase_o;

    int checks = 0;
    int errors = 0;
    bit running = 1'b0;

    always #10 clk = ~clk;

    vrc_ctrl #(
        .PIX_PER_LINE (PPL),
        .LINE_MAX     (LMAX),
        .DLY_W        (DW)
    ) u_vrc_ctrl (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .href_i        (href),
        .vref_i        (vref),
        .intpol_i      (intpol),
        .film_i        (film),
        .even_i        (even),
        .mode_o        (mode_o),
        .even_o        (even_o),
        .interp_o      (interp_o),
        .film_coef_o   (film_coef_o),
        .pip_o         (pip_o),
        .chroma_taps_o (taps_o),
        .delay_o       (delay_o),
        .pix_o         (pix_o),
        .line_o        (line_o),
        .out_line_o    (out_line_o),
        .out_valid_o   (out_valid_o),
        .coef_phase_o  (phase_o)
    );

    // Reference state built from the requirements.
    int m_mode = 0, m_even = 0, m_pix = 0, m_line = 0;

    function automatic int exp_delay(int md, int ev);
        case (md)
            1: return ev ? 4 : 3;
            2: return 1;
            3: return ev ? 3 : 2;
            default: return 0;
        endcase
    endfunction

    function automatic int exp_taps(int md);
        return (md == 1) ? 3 : (md == 3) ? 4 : 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_even = 0; m_pix = 0; m_line = 0;
        end else begin
            m_pix = href ? 0 : ((m_pix == PPL - 1) ? 0 : m_pix + 1);
            if (vref) begin
                m_mode = {film, intpol};
                m_even = even;
                m_line = 0;
            end else if (href) begin
                m_line = (m_line == LMAX) ? m_line : m_line + 1;
            end
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (running) begin
            int d, ok, ol, itp;
            d   = exp_delay(m_mode, m_even);
            ok  = (m_line >= d) ? 1 : 0;
            ol  = ok ? m_line - d : 0;
            itp = (m_mode == 1 || m_mode == 3) ? 1 : 0;
            chk("R1 mode", int'(mode_o), m_mode);
            chk("R2 parity", int'(even_o), m_even);
            chk("R3 pixel", int'(pix_o), m_pix);
            chk("R4 line", int'(line_o), m_line);
            chk("R5 delay", int'(delay_o), d);
            chk("R6 valid", int'(out_valid_o), ok);
            chk("R6 out_line", int'(out_line_o), ol);
            chk("R7 interp", int'(interp_o), itp);
            chk("R7 film_coef", int'(film_coef_o), (m_mode == 3) ? 1 : 0);
            chk("R7 pip", int'(pip_o), (m_mode == 2) ? 1 : 0);
            chk("R7 taps", int'(taps_o), exp_taps(m_mode));
            chk("R8 phase", int'(phase_o), (ok && itp) ? (ol % 4) : 0);
        end
    end

    task automatic step(bit h, bit v, bit ip, bit fl, bit ev);
        @(negedge clk);
        href = h; vref = v; intpol = ip; film = fl; even = ev;
    endtask

    task automatic run_field(bit ip, bit fl, bit ev, int lines);
        step(1'b0, 1'b1, ip, fl, ev);
        for (int ln = 0; ln < lines; ln++) begin
            for (int px = 0; px < PPL; px++) begin
                step(px == 0, 1'b0, ~ip, ~fl, ~ev);
            end
        end
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        // R9 reset state
        chk("R9 reset mode", int'(mode_o), 0);
        chk("R9 reset line", int'(line_o), 0);
        chk("R9 reset valid", int'(out_valid_o), 1);
        chk("R9 reset out_line", int'(out_line_o), 0);
        running = 1'b1;

        // Directed: every mode and parity, fields long enough to saturate.
        for (int md = 0; md < 4; md++) begin
            for (int ev = 0; ev < 2; ev++) begin
                run_field(md[0], md[1], ev[0], 20);
            end
        end
        // Corner: vref and href in the same cycle.
        step(1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
        for (int i = 0; i < 40; i++) step(i % 5 == 0, 1'b0, 1'b0, 1'b0, 1'b0);

        // Random traffic with line cadence and stray pulses.
        begin
            int cd = 0;
            for (int i = 0; i < 6000; i++) begin
                bit h, v;
                h  = (cd == 0) || ($urandom % 50 == 0);
                cd = (cd == 0) ? PPL - 1 - ($urandom % 3) : cd - 1;
                v  = ($urandom % 90 == 0);
                step(h, v, $urandom % 2, $urandom % 2, $urandom % 2);
            end
        end
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        running = 1'b0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R9 actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule